// File: doc/BRIEF.md
# ECC Error Capture Registers

This block sits beside a DRAM controller's ECC checker and keeps a record of the memory errors that checker reports. Each cycle it may receive a correctable-error pulse, an uncorrectable-error pulse, or both. It also receives the failing physical address, an 8-bit syndrome and a one-bit channel number. The block holds a sticky flag for each error class. It also holds one set of error details: the 4 KiB block address, the syndrome and the channel.

When an uncorrectable error follows a correctable one, the uncorrectable error replaces the stored details. Both flags remain set, so software that finds both flags set knows the details belong to the uncorrectable error and that the correctable error's details were lost. Software clears the flags by writing ones to them.

A two-bit enable field decides which flag classes drive a registered system-error level. Software reaches all of this through a word-addressed read/write port with byte enables. Read data appears one cycle after the read strobe.

Top module: `ecc_error_logger`

## Requirements
- R1: After reset, both flags, both enables and all stored details are zero, every register word reads zero, and `serr_out` is low.
- R2: A correctable pulse sets status bit 0 and an uncorrectable pulse sets status bit 7 at the next clock edge. The status word is at byte offset 0x8, bits 15:0, and its other status bits read zero.
- R3: When no flag is set, an error captures its details. Word 0x0 reads the failing address bits 31:12 in place, with bits 11:0 reading zero. Word 0x4 reads the syndrome in bits 7:0 and the channel in bit 8, with all other bits zero.
- R4: An uncorrectable error that arrives while only the correctable flag is set replaces the block address, syndrome and channel with its own. Both flags stay set.
- R5: An error changes only its own flag, and leaves the stored details unchanged, in two cases: a correctable error that arrives while either flag is set, and an uncorrectable error that arrives while the uncorrectable flag is set.
- R6: A write to offset 0x8 with byte enable 0 active clears status bit 0 if data bit 0 is one, and clears status bit 7 if data bit 7 is one. A zero data bit leaves its flag unchanged. Without byte enable 0, a write leaves both flags unchanged.
- R7: When an error pulse and a clear of the same flag occur in the same cycle, the flag is set after that edge.
- R8: Once both flags are clear, the next error of either kind captures fresh details.
- R9: The enable field sits in bits 31:16 of offset 0x8. Mask bit 7 (data bit 23, byte lane 2) enables correctable errors and mask bit 8 (data bit 24, byte lane 3) enables uncorrectable errors. Each bit is written only through its own lane, and the other mask bits read zero.
- R10: `serr_out` equals, one cycle later, the OR of (correctable flag AND its enable) and (uncorrectable flag AND its enable).
- R11: `reg_rdata` is updated at the edge that samples `reg_rd` and holds the word selected by `reg_addr`. Offset 0xC reads zero. Writes to offsets 0x0, 0x4 and 0xC change nothing.
- R12: When both pulses arrive together with no flag set, both flags are set and the uncorrectable error's details are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| err_addr | input | ADDR_W (32) | Failing physical address |
| err_syn | input | SYN_W (8) | ECC syndrome of the error |
| err_chan | input | 1 | Channel the error came from |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (4) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Write byte enables |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| serr_out | output | 1 | Registered system-error level |

## Verification
The bench covers every combination of two consecutive event kinds (none, correctable, uncorrectable, both) under each of the four enable settings. A design that let a later correctable error overwrite the details would fail the R5 readbacks. A design that dropped the correctable flag on an uncorrectable error would fail R4. Partial clears, clears without lane 0, and clears that collide with a new pulse are targeted because the usual bugs are clearing both flags, ignoring byte enables, or letting the clear win. `serr_out` is compared every cycle against a one-cycle-delayed model, which catches both a missing register stage and an extra one.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int BUS_W = 32;

  // Byte offsets of the register words
  localparam int OFF_ADDR   = 0;
  localparam int OFF_DETAIL = 4;
  localparam int OFF_STAT   = 8;

  // Bit positions inside the status/mask word
  localparam int STAT_CE_BIT = 0;
  localparam int STAT_UE_BIT = 7;
  localparam int MASK_LSB    = 16;
  localparam int MASK_CE_BIT = MASK_LSB + 7;
  localparam int MASK_UE_BIT = MASK_LSB + 8;

  // Assemble the status/mask word from flags and enables
  function automatic logic [BUS_W-1:0] stat_word(input logic ce, input logic ue,
                                                 input logic mce, input logic mue);
    logic [BUS_W-1:0] w;
    w = '0;
    w[STAT_CE_BIT] = ce;
    w[STAT_UE_BIT] = ue;
    w[MASK_CE_BIT] = mce;
    w[MASK_UE_BIT] = mue;
    return w;
  endfunction

  // Level that the system-error output should follow
  function automatic logic serr_level(input logic ce, input logic ue,
                                      input logic mce, input logic mue);
    return (ce & mce) | (ue & mue);
  endfunction

endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_evt,
  input  logic ue_evt,
  input  logic clr_ce,
  input  logic clr_ue,
  output logic ce_flag,
  output logic ue_flag,
  output logic cap_en
);

  // A new uncorrectable error takes the details unless one is already held.
  // A correctable error takes them only when nothing is logged.
  logic ue_takes, ce_takes;
  assign ue_takes = ue_evt & ~ue_flag;
  assign ce_takes = ce_evt & ~ce_flag & ~ue_flag;
  assign cap_en   = ue_takes | ce_takes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_flag <= 1'b0;
      ue_flag <= 1'b0;
    end else begin
      // event has priority over a clear in the same cycle
      ce_flag <= ce_evt | (ce_flag & ~clr_ce);
      ue_flag <= ue_evt | (ue_flag & ~clr_ue);
    end
  end

  AST_CE_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> ce_flag); // R7
  AST_UE_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> ue_flag); // R2
  AST_CE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ce_flag && !clr_ce |=> ce_flag); // R6
  AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ue_flag && !clr_ue |=> ue_flag); // R6

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  output logic [BLK_W-1:0]  blk_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic              chan_q
);

  logic addr_unused;
  assign addr_unused = ^err_addr[BLK_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (cap_en) begin
      blk_q  <= err_addr[ADDR_W-1:BLK_LSB];
      syn_q  <= err_syn;
      chan_q <= err_chan;
    end
  end

  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (syn_q == $past(err_syn)) && (chan_q == $past(err_chan))); // R3
  AST_DETAILS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(blk_q) && $stable(syn_q) && $stable(chan_q)); // R5

endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  parameter int REG_AW  = 4,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic [3:0]        reg_be,
  input  logic              ce_flag,
  input  logic              ue_flag,
  input  logic [BLK_W-1:0]  blk_q,
  input  logic [SYN_W-1:0]  syn_q,
  input  logic              chan_q,
  output logic              clr_ce,
  output logic              clr_ue,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              serr_out
);

  logic mask_ce, mask_ue;
  logic hit_addr, hit_detail, hit_stat;
  logic wr_stat;

  assign hit_addr   = (reg_addr == REG_AW'(OFF_ADDR));
  assign hit_detail = (reg_addr == REG_AW'(OFF_DETAIL));
  assign hit_stat   = (reg_addr == REG_AW'(OFF_STAT));
  assign wr_stat    = reg_wr & hit_stat;

  // write-one-to-clear, only through byte lane 0
  assign clr_ce = wr_stat & reg_be[0] & reg_wdata[STAT_CE_BIT];
  assign clr_ue = wr_stat & reg_be[0] & reg_wdata[STAT_UE_BIT];

  logic wdata_unused;
  assign wdata_unused = ^{reg_wdata[31:25], reg_wdata[22:8], reg_wdata[6:1], reg_be[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_ce <= 1'b0;
      mask_ue <= 1'b0;
    end else if (wr_stat) begin
      if (reg_be[2]) mask_ce <= reg_wdata[MASK_CE_BIT];
      if (reg_be[3]) mask_ue <= reg_wdata[MASK_UE_BIT];
    end
  end

  // read words
  logic [ADDR_W-1:0] addr_full;
  logic [BUS_W-1:0]  word_addr, word_detail, word_stat, rd_mux;
  assign addr_full   = {blk_q, {BLK_LSB{1'b0}}};
  assign word_addr   = BUS_W'(addr_full);
  assign word_detail = BUS_W'({chan_q, syn_q});
  assign word_stat   = stat_word(ce_flag, ue_flag, mask_ce, mask_ue);

  always_comb begin
    rd_mux = '0;
    if (hit_addr)   rd_mux = word_addr;
    if (hit_detail) rd_mux = word_detail;
    if (hit_stat)   rd_mux = word_stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      serr_out  <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      serr_out <= serr_level(ce_flag, ue_flag, mask_ce, mask_ue);
    end
  end

  AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_out) |-> $past(ce_flag | ue_flag)); // R10
  AST_SERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_flag && !ue_flag |=> !serr_out); // R10
  AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && hit_addr |=> reg_rdata[BLK_LSB-1:0] == '0); // R3
  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !hit_addr && !hit_detail && !hit_stat |=> reg_rdata == '0); // R11

endmodule

// File: rtl/ecc_error_logger.sv
module ecc_error_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 12,
  parameter int SYN_W   = 8,
  parameter int REG_AW  = 4,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  output logic              serr_out
);

  // internal events brought out as named wires
  logic ce_flag, ue_flag, cap_en, clr_ce, clr_ue;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;
  logic             chan_q;

  ecc_log_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_evt  (ce_evt),
    .ue_evt  (ue_evt),
    .clr_ce  (clr_ce),
    .clr_ue  (clr_ue),
    .ce_flag (ce_flag),
    .ue_flag (ue_flag),
    .cap_en  (cap_en)
  );

  ecc_log_capture #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .err_addr (err_addr),
    .err_syn  (err_syn),
    .err_chan (err_chan),
    .blk_q    (blk_q),
    .syn_q    (syn_q),
    .chan_q   (chan_q)
  );

  ecc_log_regs #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .SYN_W(SYN_W), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_be    (reg_be),
    .ce_flag   (ce_flag),
    .ue_flag   (ue_flag),
    .blk_q     (blk_q),
    .syn_q     (syn_q),
    .chan_q    (chan_q),
    .clr_ce    (clr_ce),
    .clr_ue    (clr_ue),
    .reg_rdata (reg_rdata),
    .serr_out  (serr_out)
  );

  AST_UE_OVERWRITES_CE: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt && ce_flag && !ue_flag && !clr_ce |=>
      ce_flag && ue_flag && (chan_q == $past(err_chan)) && (syn_q == $past(err_syn))); // R4
  AST_CE_KEEPS_DETAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && !ue_evt && (ce_flag || ue_flag) |=> $stable(syn_q) && $stable(blk_q)); // R5
  AST_BOTH_TAKE_UE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && ue_evt && !ce_flag && !ue_flag |=>
      ce_flag && ue_flag && (syn_q == $past(err_syn))); // R12

endmodule

// File: tb/ecc_error_logger_test.sv
module ecc_error_logger_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_evt = 1'b0, ue_evt = 1'b0, err_chan = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        serr_out;

  always #2 clk = ~clk;  // 250 MHz

  ecc_error_logger uut (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .serr_out(serr_out)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference model
  bit ce_m, ue_m, mce, mue, chan_m;
  logic [19:0] blk_m;
  logic [7:0]  syn_m;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; model advanced, serr checked after the edge
  task automatic cyc(bit ce, bit ue, logic [31:0] a, logic [7:0] s, bit c,
                     bit wr, bit rd, int idx, logic [31:0] wd, logic [3:0] be);
    bit nx, clr0, clr7;
    ce_evt = ce; ue_evt = ue; err_addr = a; err_syn = s; err_chan = c;
    reg_wr = wr; reg_rd = rd; reg_addr = 4'(idx * 4); reg_wdata = wd; reg_be = be;
    nx   = (ce_m && mce) || (ue_m && mue);
    clr0 = wr && idx == 2 && be[0] && wd[0];
    clr7 = wr && idx == 2 && be[0] && wd[7];
    if ((ue && !ue_m) || (ce && !ce_m && !ue_m)) begin
      blk_m = a[31:12]; syn_m = s; chan_m = c;
    end
    ce_m = ce || (ce_m && !clr0);
    ue_m = ue || (ue_m && !clr7);
    if (wr && idx == 2) begin
      if (be[2]) mce = wd[23];
      if (be[3]) mue = wd[24];
    end
    @(posedge clk);
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    check("R10 serr_out", {31'b0, serr_out}, {31'b0, nx});
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    cyc(0, 0, '0, '0, 0, 0, 1, idx, '0, '0);
    v = reg_rdata;
  endtask

  task automatic wr(int idx, logic [31:0] wd, logic [3:0] be);
    cyc(0, 0, '0, '0, 0, 1, 0, idx, wd, be);
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(0, v); check({tag, " addr word"}, v, {blk_m, 12'h000});
    rd(1, v); check({tag, " detail word"}, v, {23'h0, chan_m, syn_m});
    rd(2, v); check({tag, " status word"}, v,
                    (32'(mue) << 24) | (32'(mce) << 23) | (32'(ue_m) << 7) | 32'(ce_m));
  endtask

  task automatic event_kind(int k, logic [31:0] a, logic [7:0] s, bit c);
    cyc(k[0], k[1], a, s, c, 0, 0, 0, '0, '0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int scen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 serr after reset", {31'b0, serr_out}, 32'h0);
    check_all("R1");
    rd(3, v); check("R1 gap word", v, 32'h0);

    // sweep: enable settings x first event x second event
    scen = 0;
    for (int m = 0; m < 4; m++) begin
      wr(2, (32'(m >> 1) << 24) | (32'(m & 1) << 23), 4'b1100);
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          logic [31:0] a1, a2;
          string t1, t2;
          scen++;
          a1 = 32'h0040_0000 + 32'(scen) * 32'h0011_3ABC;
          a2 = 32'hF000_0FFF - 32'(scen) * 32'h0007_1235;
          t1 = (a == 3) ? "R12" : ((scen == 1) ? "R3" : "R8");
          event_kind(a, a1, 8'(scen * 7 + 3), scen[0]);
          if (a != 0) begin
            rd(2, v);
            check("R2 status after first event", v,
                  (32'(mue) << 24) | (32'(mce) << 23) | (32'(ue_m) << 7) | 32'(ce_m));
          end
          check_all(t1);
          if (b[1] && !ue_m && ce_m) t2 = "R4";
          else if (b != 0 && (ce_m || ue_m)) t2 = "R5";
          else if (b == 3) t2 = "R12";
          else t2 = "R3";
          event_kind(b, a2, 8'(8'hA5 ^ 8'(scen)), !scen[0]);
          check_all(t2);
          wr(2, 32'h0000_0001, 4'b0001);
          check_all("R6 clear correctable only");
          wr(2, 32'h0000_0081, 4'b0010);
          check_all("R6 no lane 0");
          wr(2, 32'h0000_0080, 4'b0001);
          check_all("R6 clear uncorrectable");
        end
      end
    end

    // collision of clear and new event
    wr(2, 32'h0180_0000, 4'b1100);
    cyc(1, 0, 32'h1234_5678, 8'h3C, 1, 1, 0, 2, 32'h0000_0081, 4'b0001);
    check_all("R7 correctable vs clear");
    cyc(0, 1, 32'h8765_4321, 8'hC3, 0, 1, 0, 2, 32'h0000_0081, 4'b0001);
    check_all("R7 uncorrectable vs clear");
    cyc(0, 0, '0, '0, 0, 0, 0, 0, '0, '0);
    wr(2, 32'h0000_0081, 4'b0001);
    check_all("R7 cleared");

    // mask field readback and lanes
    wr(2, 32'hFFFF_FF7E, 4'b1100);
    check_all("R9 mask set all");
    wr(2, 32'h0000_0000, 4'b0100);
    check_all("R9 lane 2 only");
    wr(2, 32'h0000_0000, 4'b1000);
    check_all("R9 lane 3 only");

    // read-only and unused words ignore writes
    event_kind(2, 32'hDEAD_B123, 8'h5A, 1);
    wr(0, 32'hFFFF_FFFF, 4'hF);
    wr(1, 32'hFFFF_FFFF, 4'hF);
    wr(3, 32'hFFFF_FFFF, 4'hF);
    check_all("R11 writes to read-only words");
    rd(3, v); check("R11 gap word", v, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule